// File: doc/BRIEF.md
# Routed Interrupt Controller with Dual Arbitration

This block gathers 64 interrupt inputs and sends each one to one of eight destinations: the normal interrupt line (IRQ), the fast interrupt line (FIQ), or one of six auxiliary lines. Software sets up each input through its own 8-bit setup byte. The byte holds an enable, a trigger mode and a destination number. The trigger mode is active-high level, rising edge, falling edge, or both edges. Every input passes through a two-flop synchronizer. Edge events are held in sticky flags. Software reads these flags as two 32-bit words and clears them by writing 1 to a bit.

The IRQ path and the FIQ path each have their own arbiter. Each arbiter picks one winning input from the sources routed to its path and reports that index through a priority register. The arbiter works in one of two modes. In fixed mode the lowest index wins. In rotating mode the search starts just after the last winner that software read. Each destination output is high whenever at least one enabled source routed to it is pending.

Top module: `intc_router`

## Requirements
- R1: After reset every setup byte reads 0x00, both edge status words read 0, every output is low, and both priority registers read 0x80.
- R2: A byte write (byte select high) to address 0x40+n stores the setup of source n. Bit 3 is the enable, bits 2:0 are the destination, bit 5 is the rising trigger and bit 6 is the falling trigger. A byte read returns these bits with bits 7 and 4 as 0, so a write of 0xFF reads back as 0x6F.
- R3: A source with bits 6:5 both 0 is level triggered. It is pending while it is enabled and its synchronized input is high. A level source never sets an edge status flag.
- R4: An edge event selected by bit 5 or bit 6 sets a status flag about three cycles after the input changes. Sources 0–31 appear in word 0x80 and sources 32–63 in word 0x84, with bit i of each word for source base+i. An edge that was not selected sets no flag.
- R5: An edge is captured even while its source is disabled. Once the source is enabled, the captured edge makes it pending.
- R6: A word write to 0x80 or 0x84 clears every status flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R7: Destination 0 drives irq_o, destination 1 drives fiq_o, and destinations 2 to 7 drive aux_o[0] to aux_o[5]. Each output is high exactly when an enabled, pending source is routed to it.
- R8: In fixed mode a priority read returns the lowest pending source index routed to that path in bits 5:0.
- R9: Writing bit 6 of a priority register (word 0x20 for IRQ, 0x24 for FIQ) selects rotating mode and reads back in bit 6. In rotating mode the search starts at the index after the winner of the previous read of that register, and wraps from 63 to 0.
- R10: Bit 7 of a priority read is 1 and bits 5:0 are 0 when no source routed to that path is pending.
- R11: The IRQ and FIQ arbiters use only the sources routed to their own path.
- R12: A word access (byte select low) in the setup region 0x40–0x7F is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Raw interrupt inputs |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_re | input | 1 | Read strobe; data appears one cycle later |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| aux_o | output | AUX_N | Auxiliary destination outputs |

## Verification
Rotation is the hardest behaviour to reach from the ports. The arbiter's pointer moves only when software reads a priority register while a source is pending. Reaching the wrap from a high index back to a low one therefore needs two level sources held high together and a chain of back-to-back reads, each of which must return a different winner. The captured-while-disabled case is similar. An edge is pulsed on a source that is disabled, the status word is read to confirm the flag is set, and only then is the enable written. The output must rise in the same cycle that the setup write lands.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int ADDR_W_DEF  = 8;
    localparam int NUM_DEST    = 8;
    localparam int AUX_N_DEF   = 6;

    localparam logic [7:0] A_PRIO_IRQ  = 8'h20;
    localparam logic [7:0] A_PRIO_FIQ  = 8'h24;
    localparam logic [7:0] A_CFG_BASE  = 8'h40;
    localparam logic [7:0] A_STAT_LO   = 8'h80;
    localparam logic [7:0] A_STAT_HI   = 8'h84;

    localparam logic [2:0] DST_IRQ = 3'd0;
    localparam logic [2:0] DST_FIQ = 3'd1;

    typedef struct packed {
        logic       fall;
        logic       rise;
        logic       en;
        logic [2:0] dest;
    } src_cfg_t;

    function automatic src_cfg_t byte_to_cfg(input logic [7:0] b);
        src_cfg_t c;
        c.fall = b[6];
        c.rise = b[5];
        c.en   = b[3];
        c.dest = b[2:0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input src_cfg_t c);
        return {1'b0, c.fall, c.rise, 1'b0, c.en, c.dest};
    endfunction

    function automatic logic is_edge_mode(input src_cfg_t c);
        return c.fall | c.rise;
    endfunction

endpackage

// File: rtl/intc_src_slice.sv
module intc_src_slice
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     raw_in,
    input  src_cfg_t cfg,
    input  logic     clr,
    output logic     pend,
    output logic     flag
);
    logic s1_q, s2_q, prev_q, flag_q;
    logic rise_ev, fall_ev, hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            s1_q   <= raw_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
            flag_q <= hit | (flag_q & ~clr);
        end
    end

    always_comb begin
        rise_ev = s2_q & ~prev_q;
        fall_ev = ~s2_q & prev_q;
        hit     = (cfg.rise & rise_ev) | (cfg.fall & fall_ev);
        pend    = cfg.en & (is_edge_mode(cfg) ? flag_q : s2_q);
        flag    = flag_q;
    end

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        flag_q && !clr |=> flag_q); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr && !hit |=> !flag_q); // R6

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int N = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 rot,
    input  logic                 adv,
    output logic [$clog2(N)-1:0] win_idx,
    output logic                 none
);
    localparam int IW = $clog2(N);

    logic [IW-1:0]  last_q, start, off;
    logic [2*N-1:0] dbl;
    logic [N-1:0]   view, below;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IW'(N - 1);
        else if (adv && !none)
            last_q <= win_idx;
    end

    always_comb begin
        start = rot ? last_q + 1'b1 : '0;
        dbl   = {req, req} >> start;
        view  = dbl[N-1:0];
        off   = '0;
        for (int i = N - 1; i >= 0; i--)
            if (view[i]) off = IW'(i);
        none    = ~|req;
        win_idx = none ? '0 : start + off;
    end

    always_comb
        for (int i = 0; i < N; i++)
            below[i] = (IW'(i) < win_idx);

    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
        !none |-> req[win_idx]); // R8
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (rst)
        !rot && !none |-> (req & below) == '0); // R8
    AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        none |-> win_idx == '0); // R10

endmodule

// File: rtl/intc_router.sv
module intc_router
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int AUX_N   = AUX_N_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_we,
    input  logic               bus_byte,
    input  logic               bus_re,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o,
    output logic [AUX_N-1:0]   aux_o
);
    localparam int IW = $clog2(NUM_SRC);

    src_cfg_t             cfg_q [NUM_SRC];
    logic                 rot_irq_q, rot_fiq_q;
    logic [NUM_SRC-1:0]   pend, flag, clr;
    logic [NUM_SRC-1:0]   req_irq, req_fiq, en_vec;
    logic [63:0]          flag64, wd64;
    logic [NUM_DEST-1:0]  dest_any;
    logic [IW-1:0]        irq_idx, fiq_idx;
    logic                 irq_none, fiq_none;
    logic                 in_cfg, wr_word, rd_word;
    logic [31:0]          rd_val;

    always_comb begin
        in_cfg  = (bus_addr >= ADDR_W'(A_CFG_BASE)) &&
                  (bus_addr <  ADDR_W'(A_CFG_BASE) + ADDR_W'(NUM_SRC));
        wr_word = bus_we & ~bus_byte;
        rd_word = bus_re & ~bus_byte;
        wd64    = '0;
        if (wr_word && bus_addr == ADDR_W'(A_STAT_LO)) wd64[31:0]  = bus_wdata;
        if (wr_word && bus_addr == ADDR_W'(A_STAT_HI)) wd64[63:32] = bus_wdata;
        clr     = wd64[NUM_SRC-1:0];
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[n] <= '0;
            else if (bus_we && bus_byte &&
                     bus_addr == ADDR_W'(A_CFG_BASE) + ADDR_W'(n))
                cfg_q[n] <= byte_to_cfg(bus_wdata[7:0]);
        end

        intc_src_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .raw_in (src_in[n]),
            .cfg    (cfg_q[n]),
            .clr    (clr[n]),
            .pend   (pend[n]),
            .flag   (flag[n])
        );

        assign req_irq[n] = pend[n] && cfg_q[n].dest == DST_IRQ;
        assign req_fiq[n] = pend[n] && cfg_q[n].dest == DST_FIQ;
        assign en_vec[n]  = cfg_q[n].en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rot_irq_q <= 1'b0;
            rot_fiq_q <= 1'b0;
        end else begin
            if (wr_word && bus_addr == ADDR_W'(A_PRIO_IRQ)) rot_irq_q <= bus_wdata[6];
            if (wr_word && bus_addr == ADDR_W'(A_PRIO_FIQ)) rot_fiq_q <= bus_wdata[6];
        end
    end

    intc_arbiter #(.N(NUM_SRC)) u_arb_irq (
        .clk     (clk),
        .rst     (rst),
        .req     (req_irq),
        .rot     (rot_irq_q),
        .adv     (rd_word && bus_addr == ADDR_W'(A_PRIO_IRQ)),
        .win_idx (irq_idx),
        .none    (irq_none)
    );

    intc_arbiter #(.N(NUM_SRC)) u_arb_fiq (
        .clk     (clk),
        .rst     (rst),
        .req     (req_fiq),
        .rot     (rot_fiq_q),
        .adv     (rd_word && bus_addr == ADDR_W'(A_PRIO_FIQ)),
        .win_idx (fiq_idx),
        .none    (fiq_none)
    );

    always_comb begin
        dest_any = '0;
        for (int n = 0; n < NUM_SRC; n++)
            for (int d = 0; d < NUM_DEST; d++)
                if (pend[n] && cfg_q[n].dest == 3'(d))
                    dest_any[d] = 1'b1;
        irq_o = dest_any[0];
        fiq_o = dest_any[1];
        aux_o = dest_any[2 +: AUX_N];
    end

    always_comb begin
        flag64 = 64'(flag);
        rd_val = '0;
        if (bus_byte) begin
            if (in_cfg)
                rd_val[7:0] = cfg_to_byte(cfg_q[IW'(bus_addr - ADDR_W'(A_CFG_BASE))]);
        end else begin
            case (bus_addr)
                ADDR_W'(A_PRIO_IRQ): rd_val[7:0] = {irq_none, rot_irq_q, 6'(irq_idx)};
                ADDR_W'(A_PRIO_FIQ): rd_val[7:0] = {fiq_none, rot_fiq_q, 6'(fiq_idx)};
                ADDR_W'(A_STAT_LO):  rd_val = flag64[31:0];
                ADDR_W'(A_STAT_HI):  rd_val = flag64[63:32];
                default:             rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_val;
    end

    AST_RESET_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> en_vec == '0 && flag == '0); // R1
    AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !irq_none); // R7
    AST_FIQ_HAS_WINNER: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> !fiq_none); // R11
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        en_vec == '0 |-> !irq_o && !fiq_o && aux_o == '0); // R7

endmodule

// File: tb/intc_router_test.sv
module intc_router_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src_in;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_byte, bus_re;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    logic [5:0]  aux_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    intc_router uut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .fiq_o(fiq_o), .aux_o(aux_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wait_n(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic b);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_byte = b; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic b, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_byte = b; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        src_in = '0; bus_we = 0; bus_re = 0; bus_byte = 0;
        bus_addr = '0; bus_wdata = '0; rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] outs();
        return 32'({aux_o, fiq_o, irq_o});
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 outputs", outs(), 0);
        rd(8'h40, 1, d); chk("R1 cfg0", d, 0);
        rd(8'h7F, 1, d); chk("R1 cfg63", d, 0);
        rd(8'h80, 0, d); chk("R1 stat lo", d, 0);
        rd(8'h84, 0, d); chk("R1 stat hi", d, 0);
        rd(8'h20, 0, d); chk("R1 prio irq", d, 32'h80);
        rd(8'h24, 0, d); chk("R1 prio fiq", d, 32'h80);
    endtask

    task automatic t_cfg_rw();
        logic [31:0] d;
        do_reset();
        wr(8'h45, 32'hFF, 1); rd(8'h45, 1, d); chk("R2 readback FF", d, 32'h6F);
        wr(8'h46, 32'h2B, 1); rd(8'h46, 1, d); chk("R2 readback 2B", d, 32'h2B);
        wr(8'h44, 32'h08, 0); rd(8'h44, 1, d); chk("R12 word write ignored", d, 0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        wr(8'h4C, 32'h08, 1);
        src_in[12] = 1'b1; wait_n(3);
        chk("R3 level high", 32'(irq_o), 1);
        rd(8'h80, 0, d); chk("R3 no flag", d, 0);
        src_in[12] = 1'b0; wait_n(3);
        chk("R3 level low", 32'(irq_o), 0);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        do_reset();
        wr(8'h43, 32'h20, 1);
        wr(8'h68, 32'h40, 1);
        src_in[3] = 1'b1; src_in[40] = 1'b1; wait_n(3);
        rd(8'h80, 0, d); chk("R4 rise lo", d, 32'h8);
        rd(8'h84, 0, d); chk("R4 rise on fall-only", d, 0);
        src_in[40] = 1'b0; wait_n(3);
        rd(8'h84, 0, d); chk("R4 fall hi", d, 32'h100);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        do_reset();
        wr(8'h43, 32'h20, 1);
        src_in[3] = 1'b1; wait_n(2); src_in[3] = 1'b0; wait_n(3);
        chk("R5 off quiet", 32'(irq_o), 0);
        rd(8'h80, 0, d); chk("R5 flag while off", d, 32'h8);
        wr(8'h43, 32'h28, 1);
        chk("R5 pending on enable", 32'(irq_o), 1);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        do_reset();
        wr(8'h43, 32'h28, 1);
        wr(8'h44, 32'h20, 1);
        src_in[3] = 1'b1; src_in[4] = 1'b1; wait_n(3);
        wr(8'h80, 32'h0, 0);
        rd(8'h80, 0, d); chk("R6 zero write", d, 32'h18);
        wr(8'h80, 32'h8, 0);
        rd(8'h80, 0, d); chk("R6 one clears", d, 32'h10);
        chk("R6 irq drops", 32'(irq_o), 0);
    endtask

    task automatic t_route();
        do_reset();
        src_in[20] = 1'b1; wait_n(3);
        for (int k = 0; k < 8; k++) begin
            wr(8'h54, 32'(8 | k), 1);
            chk($sformatf("R7 dest %0d", k), outs(), 32'(1 << k));
        end
        wr(8'h54, 32'h07, 1);
        chk("R7 disabled", outs(), 0);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        do_reset();
        wr(8'h49, 32'h08, 1); wr(8'h61, 32'h08, 1);
        src_in[9] = 1'b1; src_in[33] = 1'b1; wait_n(3);
        rd(8'h20, 0, d); chk("R8 lowest", d, 32'h09);
        rd(8'h20, 0, d); chk("R8 stays", d, 32'h09);
        src_in[9] = 1'b0; wait_n(3);
        rd(8'h20, 0, d); chk("R8 next", d, 32'h21);
    endtask

    task automatic t_rotate();
        logic [31:0] d;
        do_reset();
        wr(8'h20, 32'h40, 0);
        rd(8'h20, 0, d); chk("R10 none rot", d, 32'hC0);
        wr(8'h45, 32'h08, 1); wr(8'h4A, 32'h08, 1);
        src_in[5] = 1'b1; src_in[10] = 1'b1; wait_n(3);
        rd(8'h20, 0, d); chk("R9 first", d, 32'h45);
        rd(8'h20, 0, d); chk("R9 second", d, 32'h4A);
        rd(8'h20, 0, d); chk("R9 wrap", d, 32'h45);
    endtask

    task automatic t_paths();
        logic [31:0] d;
        do_reset();
        wr(8'h47, 32'h09, 1);
        src_in[7] = 1'b1; wait_n(3);
        rd(8'h20, 0, d); chk("R11 irq sees none", d, 32'h80);
        rd(8'h24, 0, d); chk("R11 fiq winner", d, 32'h07);
        wr(8'h45, 32'h08, 1);
        src_in[5] = 1'b1; wait_n(3);
        rd(8'h20, 0, d); chk("R11 irq winner", d, 32'h05);
        rd(8'h24, 0, d); chk("R11 fiq unchanged", d, 32'h07);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_cfg_rw(); t_level(); t_edges(); t_disabled();
                t_w1c(); t_route(); t_fixed(); t_rotate(); t_paths();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule